// File: doc/BRIEF.md
# Quad Output Power Sequencer Controller

This block brings four supply-enable outputs up and down in a fixed, timed order. Two comparator flags describe the monitored rail. One says the rail is above its lower limit, the other says it is above its upper limit. The rail counts as inside its window when the first flag is high and the second is low. While the rail is inside its window and a sequence request is active, the controller waits a programmable start delay. It then raises outputs A, B, C and D in turn, with a programmable stage delay before each of B, C and D.

When the request is withdrawn, the same start delay is counted again. The outputs then drop in the order D, C, B, A, and each gap reuses the stage delay of the output that has just turned off. If the rail leaves its window at any moment, all four outputs drop together on one clock edge. A window-fault flag reports the rail state with a fast set and a filtered clear. A status code shows the controller phase.

The delays are counts in clock cycles and are held steady by the surrounding logic. The comparator and request inputs are asynchronous, and each passes through a two-flop synchronizer before use. The output polarity and the request polarity are chosen when the block is built. In the active-low request build, the board pulls the request pin low so that an undriven request means "enabled".

Top module: `quad_seq_ctrl`

## Requirements
- R1: While `rst` or `por_i` is high, every enable is inactive, `state_o` is 0 (idle) and `fault_o` is 1. `por_i` is sampled on the clock edge without synchronization.
- R2: From idle, a start needs both conditions: the window is valid (`uv_ok_i`=1 and `ov_hi_i`=0) and the request is active. Otherwise the block stays idle with all enables off.
- R3: After the controller enters the start phase (`state_o`=1), output A turns on exactly `start_dly_i`+1 cycles later. A window loss during the start phase returns the block to idle, and the next start counts again from zero.
- R4: Outputs turn on one at a time in the order A, B, C, D. B follows A after `dly_b_i`+1 cycles, C follows B after `dly_c_i`+1 cycles, and D follows C after `dly_d_i`+1 cycles. A stage count of zero therefore means the next clock.
- R5: A synchronized window loss turns all active enables off on one edge. This happens in any phase, and the status returns to 0. An input change reaches the outputs on the third rising edge after it is applied.
- R6: If the request is withdrawn with all four outputs on, the status becomes 4. D turns off `start_dly_i`+1 cycles later. C follows D after `dly_d_i`+1 cycles, B follows C after `dly_c_i`+1 cycles, and A follows B after `dly_b_i`+1 cycles.
- R7: If the request is withdrawn during the start phase, the block goes straight to idle. If it is withdrawn while outputs are turning on, the highest output that is on turns off on the next edge, and turn-off then continues in reverse order.
- R8: If the request returns during the turn-off wait (status 4), the block goes back to all-on. If it returns while outputs are turning off, turn-on resumes from the current output with the forward stage delays.
- R9: `fault_o` goes to 1 on the first edge that samples a synchronized window loss. It returns to 0 only after `FILT_CYC` consecutive valid samples, and any invalid sample restarts that count.
- R10: With `OUT_ACT_LOW`=1 every enable bit is inverted. With `REQ_ACT_LOW`=1 the request is active while `seq_req_i` is low.
- R11: `en_o` bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. The `state_o` codes are:
  - 0: idle
  - 1: start delay
  - 2: turning on
  - 3: all on
  - 4: turn-off wait
  - 5: turning off

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on reset hold, synchronous, active high |
| uv_ok_i | input | 1 | Rail above its lower limit (asynchronous) |
| ov_hi_i | input | 1 | Rail above its upper limit (asynchronous) |
| seq_req_i | input | 1 | Sequence request, polarity set by REQ_ACT_LOW (asynchronous) |
| start_dly_i | input | CW | Start delay count, used for both turn-on and turn-off |
| dly_b_i | input | CW | Stage count between A and B |
| dly_c_i | input | CW | Stage count between B and C |
| dly_d_i | input | CW | Stage count between C and D |
| en_o | output | 4 | Enables, bit 0 = A through bit 3 = D, polarity set by OUT_ACT_LOW |
| fault_o | output | 1 | Window fault, fast set and filtered clear |
| state_o | output | 3 | Phase code as listed in R11 |

## Verification
The assertions rely on a few conditions holding at the inputs. Reset is applied at time zero for several cycles. The delay counts do not change while a delay is being timed. The window and request seen by the sequencer are the synchronized copies, so the properties are written against those internal signals rather than the raw pins. The stimulus drives every pin on the falling edge, leaves the delay inputs fixed for the whole run, and pulses the comparators in whole clock cycles. A second instance built with both polarities inverted is driven with the inverted request, so its outputs can be compared bit for bit against the first instance.

// File: rtl/quad_seq_pkg.sv
package quad_seq_pkg;

    localparam int NOUT = 4;
    localparam int LVLW = $clog2(NOUT + 1);

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_RAMP_UP = 3'd2,
        ST_ALL_ON  = 3'd3,
        ST_STOP    = 3'd4,
        ST_RAMP_DN = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic req;
        logic ov_hi;
        logic uv_ok;
    } mon_t;

    // Number of outputs on -> thermometer enable vector (bit 0 = first output)
    function automatic logic [NOUT-1:0] lvl_to_en(input logic [LVLW-1:0] lvl);
        logic [NOUT-1:0] en;
        for (int i = 0; i < NOUT; i++) begin
            en[i] = (LVLW'(i) < lvl);
        end
        return en;
    endfunction

endpackage

// File: rtl/qs_sync.sv
module qs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/qs_win_filter.sv
module qs_win_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic win,
    output logic fault
);
    localparam int FW = $clog2(FILT_CYC + 1);

    logic [FW-1:0] good_cnt;

    always_ff @(posedge clk) begin
        if (rst || hold || !win) begin
            fault    <= 1'b1;
            good_cnt <= '0;
        end else if (fault) begin
            if (good_cnt == FW'(FILT_CYC - 1)) begin
                fault    <= 1'b0;
                good_cnt <= '0;
            end else begin
                good_cnt <= good_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qs_step_fsm.sv
module qs_step_fsm
    import quad_seq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         hold,
    input  logic                         win,
    input  logic                         req,
    input  logic [CW-1:0]                start_dly,
    input  logic [NOUT-1:1][CW-1:0]      stage_dly,
    output seq_state_e                   st_q,
    output logic [LVLW-1:0]              lvl_q
);
    seq_state_e      st_n;
    logic [LVLW-1:0] lvl_n;
    logic [CW-1:0]   cnt_q, cnt_n, cur_dly;

    // Stage delay of the output indexed by the current level (both directions)
    always_comb begin
        cur_dly = '0;
        for (int i = 1; i < NOUT; i++) begin
            if (lvl_q == LVLW'(i)) cur_dly = stage_dly[i];
        end
    end

    always_comb begin
        st_n  = st_q;
        lvl_n = lvl_q;
        cnt_n = cnt_q;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_n  = ST_START;
                    cnt_n = '0;
                end
            end
            ST_START: begin
                if (!req) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else if (cnt_q == start_dly) begin
                    lvl_n = LVLW'(1);
                    cnt_n = '0;
                    st_n  = ST_RAMP_UP;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_RAMP_UP: begin
                if (!req) begin
                    lvl_n = lvl_q - 1'b1;
                    cnt_n = '0;
                    st_n  = (lvl_q == LVLW'(1)) ? ST_IDLE : ST_RAMP_DN;
                end else if (cnt_q == cur_dly) begin
                    lvl_n = lvl_q + 1'b1;
                    cnt_n = '0;
                    if (lvl_q == LVLW'(NOUT - 1)) st_n = ST_ALL_ON;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_ALL_ON: begin
                if (!req) begin
                    st_n  = ST_STOP;
                    cnt_n = '0;
                end
            end
            ST_STOP: begin
                if (req) begin
                    st_n  = ST_ALL_ON;
                    cnt_n = '0;
                end else if (cnt_q == start_dly) begin
                    lvl_n = LVLW'(NOUT - 1);
                    cnt_n = '0;
                    st_n  = ST_RAMP_DN;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_RAMP_DN: begin
                if (req) begin
                    st_n  = ST_RAMP_UP;
                    cnt_n = '0;
                end else if (cnt_q == cur_dly) begin
                    lvl_n = lvl_q - 1'b1;
                    cnt_n = '0;
                    if (lvl_q == LVLW'(1)) st_n = ST_IDLE;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                lvl_n = '0;
                cnt_n = '0;
            end
        endcase
        if (!win) begin
            st_n  = ST_IDLE;
            lvl_n = '0;
            cnt_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            st_q  <= ST_IDLE;
            lvl_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            lvl_q <= lvl_n;
            cnt_q <= cnt_n;
        end
    end
endmodule

// File: rtl/quad_seq_ctrl.sv
module quad_seq_ctrl
    import quad_seq_pkg::*;
#(
    parameter int CW          = 16,
    parameter int FILT_CYC    = 8,
    parameter bit OUT_ACT_LOW = 1'b0,
    parameter bit REQ_ACT_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por_i,
    input  logic          uv_ok_i,
    input  logic          ov_hi_i,
    input  logic          seq_req_i,
    input  logic [CW-1:0] start_dly_i,
    input  logic [CW-1:0] dly_b_i,
    input  logic [CW-1:0] dly_c_i,
    input  logic [CW-1:0] dly_d_i,
    output logic [3:0]    en_o,
    output logic          fault_o,
    output logic [2:0]    state_o
);
    mon_t                    mon_raw, mon_s;
    logic                    win_s, req_s;
    logic [NOUT-1:1][CW-1:0] stage_dly;
    seq_state_e              st;
    logic [LVLW-1:0]         lvl;
    logic [NOUT-1:0]         en_act;

    assign mon_raw = '{req: seq_req_i, ov_hi: ov_hi_i, uv_ok: uv_ok_i};

    qs_sync #(.W($bits(mon_t))) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (mon_raw),
        .q   (mon_s)
    );

    assign win_s = mon_s.uv_ok & ~mon_s.ov_hi;

    generate
        if (REQ_ACT_LOW) begin : g_req_lo
            assign req_s = ~mon_s.req;
        end else begin : g_req_hi
            assign req_s = mon_s.req;
        end
    endgenerate

    assign stage_dly[1] = dly_b_i;
    assign stage_dly[2] = dly_c_i;
    assign stage_dly[3] = dly_d_i;

    qs_win_filter #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk   (clk),
        .rst   (rst),
        .hold  (por_i),
        .win   (win_s),
        .fault (fault_o)
    );

    qs_step_fsm #(.CW(CW)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .hold      (por_i),
        .win       (win_s),
        .req       (req_s),
        .start_dly (start_dly_i),
        .stage_dly (stage_dly),
        .st_q      (st),
        .lvl_q     (lvl)
    );

    assign en_act  = lvl_to_en(lvl);
    assign state_o = st;

    generate
        if (OUT_ACT_LOW) begin : g_out_lo
            assign en_o = ~en_act;
        end else begin : g_out_hi
            assign en_o = en_act;
        end
    endgenerate
endmodule

// File: rtl/quad_seq_ctrl_chk.sv
module quad_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_i,
    input logic       win_s,
    input logic       req_s,
    input logic [3:0] en_act,
    input logic       fault_o,
    input logic [2:0] state_o
);
    assert_por_clears_R1: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (en_act == 4'd0 && state_o == 3'd0 && fault_o));

    assert_idle_needs_window_and_req_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && !(win_s && req_s)) |=> (state_o == 3'd0 && en_act == 4'd0));

    assert_a_only_from_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(en_act[0]) |-> ($past(state_o) == 3'd1));

    assert_one_step_at_a_time_R4: assert property (@(posedge clk) disable iff (rst)
        (win_s && !por_i) |=> ($countones(en_act ^ $past(en_act)) <= 1));

    assert_thermometer_R11: assert property (@(posedge clk) disable iff (rst)
        ((en_act & (en_act + 4'd1)) == 4'd0));

    assert_window_loss_collapse_R5: assert property (@(posedge clk) disable iff (rst)
        !win_s |=> (en_act == 4'd0 && state_o == 3'd0));

    assert_reassert_in_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && req_s && win_s && !por_i) |=> (state_o == 3'd3));

    assert_fault_fast_set_R9: assert property (@(posedge clk) disable iff (rst)
        !win_s |=> fault_o);

    assert_fault_clear_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_o) |-> $past(win_s));
endmodule

bind quad_seq_ctrl quad_seq_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .por_i   (por_i),
    .win_s   (win_s),
    .req_s   (req_s),
    .en_act  (en_act),
    .fault_o (fault_o),
    .state_o (state_o)
);

// File: tb/quad_seq_ctrl_tb_top.sv
module quad_seq_ctrl_tb_top;
    localparam int CW   = 16;
    localparam int FILT = 8;
    localparam int SD   = 5;
    localparam int DB   = 0;
    localparam int DC   = 3;
    localparam int DD   = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, por = 1'b0, uv = 1'b0, ov = 1'b0, req = 1'b0;
    logic [CW-1:0] sd_v = CW'(SD), db_v = CW'(DB), dc_v = CW'(DC), dd_v = CW'(DD);
    logic [3:0] en_o, en_lo;
    logic       fault_o, flt_lo;
    logic [2:0] state_o, st_lo;

    quad_seq_ctrl #(.CW(CW), .FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst(rst), .por_i(por), .uv_ok_i(uv), .ov_hi_i(ov), .seq_req_i(req),
        .start_dly_i(sd_v), .dly_b_i(db_v), .dly_c_i(dc_v), .dly_d_i(dd_v),
        .en_o(en_o), .fault_o(fault_o), .state_o(state_o));

    quad_seq_ctrl #(.CW(CW), .FILT_CYC(FILT), .OUT_ACT_LOW(1'b1), .REQ_ACT_LOW(1'b1)) dut_lo_i (
        .clk(clk), .rst(rst), .por_i(por), .uv_ok_i(uv), .ov_hi_i(ov), .seq_req_i(~req),
        .start_dly_i(sd_v), .dly_b_i(db_v), .dly_c_i(dc_v), .dly_d_i(dd_v),
        .en_o(en_lo), .fault_o(flt_lo), .state_o(st_lo));

    int    checks = 0, errors = 0;
    bit    done = 0, started = 0;
    string cur_req = "R1";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_phase = 0, m_on = 0, m_wait = 0, m_flt = 1, m_good = 0;
    bit  p1_uv, p1_ov, p1_rq, p2_uv, p2_ov, p2_rq;

    function automatic int gap_of(input int k);
        if (k == 1) return DB;
        if (k == 2) return DC;
        return DD;
    endfunction

    always @(posedge clk) begin
        bit ok, want;
        ok   = p2_uv && !p2_ov;
        want = p2_rq;
        started = 1;
        if (rst || por) begin
            m_phase = 0; m_on = 0; m_wait = 0; m_flt = 1; m_good = 0;
        end else begin
            if (!ok) begin m_flt = 1; m_good = 0; end
            else if (m_flt == 1) begin
                m_good += 1;
                if (m_good == FILT) begin m_flt = 0; m_good = 0; end
            end
            if (!ok) begin m_phase = 0; m_on = 0; m_wait = 0; end
            else if (m_phase == 0) begin
                if (want) begin m_phase = 1; m_wait = 0; end
            end else if (m_phase == 1) begin
                if (!want) m_phase = 0;
                else if (m_wait == SD) begin m_on = 1; m_wait = 0; m_phase = 2; end
                else m_wait += 1;
            end else if (m_phase == 2) begin
                if (!want) begin m_on -= 1; m_wait = 0; m_phase = (m_on == 0) ? 0 : 5; end
                else if (m_wait == gap_of(m_on)) begin
                    m_on += 1; m_wait = 0; if (m_on == 4) m_phase = 3;
                end else m_wait += 1;
            end else if (m_phase == 3) begin
                if (!want) begin m_phase = 4; m_wait = 0; end
            end else if (m_phase == 4) begin
                if (want) begin m_phase = 3; m_wait = 0; end
                else if (m_wait == SD) begin m_on = 3; m_wait = 0; m_phase = 5; end
                else m_wait += 1;
            end else begin
                if (want) begin m_phase = 2; m_wait = 0; end
                else if (m_wait == gap_of(m_on)) begin
                    m_on -= 1; m_wait = 0; if (m_on == 0) m_phase = 0;
                end else m_wait += 1;
            end
        end
        if (rst) begin
            p1_uv = 0; p1_ov = 0; p1_rq = 0; p2_uv = 0; p2_ov = 0; p2_rq = 0;
        end else begin
            p2_uv = p1_uv; p2_ov = p1_ov; p2_rq = p1_rq;
            p1_uv = uv; p1_ov = ov; p1_rq = req;
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_en;
            exp_en = (1 << m_on) - 1;
            chk(cur_req, "en_o model", int'(en_o), exp_en);
            chk("R10", "inverted en_o", int'(en_lo), (~exp_en) & 15);
            chk(m_phase == 0 ? "R9" : cur_req, "fault_o model", int'(fault_o), m_flt);
            chk("R11", "state_o model", int'(state_o), m_phase);
            chk("R10", "inverted-request state", int'(st_lo), m_phase);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_en(input logic [3:0] want, output int n);
        n = 0;
        while (en_o !== want && n < 400) begin @(negedge clk); n++; end
    endtask

    task automatic wait_flt(input logic want, output int n);
        n = 0;
        while (fault_o !== want && n < 400) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        step(5);
        chk("R1", "reset en_o", int'(en_o), 0);
        chk("R11", "reset state", int'(state_o), 0);
        chk("R1", "reset fault", int'(fault_o), 1);
        rst = 0;

        // R2: request active but rail above upper limit
        cur_req = "R2";
        uv = 1; ov = 1; req = 1;
        step(20);
        chk("R2", "no start outside window", int'(en_o), 0);
        chk("R2", "idle outside window", int'(state_o), 0);
        req = 0; ov = 0;
        cur_req = "R9";
        wait_flt(1'b0, n);
        chk("R9", "fault clear edges", n, 2 + FILT);

        // R3 / R4 turn-on
        cur_req = "R3";
        req = 1;
        wait_en(4'b0001, n); chk("R3", "A edges from request", n, SD + 4);
        cur_req = "R4";
        wait_en(4'b0011, n); chk("R4", "B after A (zero count)", n, DB + 1);
        wait_en(4'b0111, n); chk("R4", "C after B", n, DC + 1);
        wait_en(4'b1111, n); chk("R4", "D after C", n, DD + 1);
        chk("R11", "all-on code", int'(state_o), 3);

        // R6 turn-off
        cur_req = "R6";
        req = 0;
        step(3);
        chk("R6", "turn-off wait code", int'(state_o), 4);
        wait_en(4'b0111, n); chk("R6", "D off after start delay", n, SD + 1);
        wait_en(4'b0011, n); chk("R6", "C off uses D count", n, DD + 1);
        wait_en(4'b0001, n); chk("R6", "B off uses C count", n, DC + 1);
        wait_en(4'b0000, n); chk("R6", "A off uses B count", n, DB + 1);

        // R3 window glitch during start: timer restarts from zero
        cur_req = "R3";
        req = 1;
        step(6);
        chk("R3", "in start phase", int'(state_o), 1);
        uv = 0; step(1); uv = 1;
        wait_en(4'b0001, n); chk("R3", "A after restart", n, SD + 4);
        wait_en(4'b1111, n);

        // R5 collapse
        cur_req = "R5";
        ov = 1;
        step(2);
        chk("R5", "outputs still on before sync", int'(en_o), 15);
        step(1);
        chk("R5", "all off together", int'(en_o), 0);
        chk("R5", "idle after collapse", int'(state_o), 0);
        chk("R9", "fault set with collapse", int'(fault_o), 1);
        ov = 0;
        wait_en(4'b1111, n);

        // R8 reassert in turn-off wait and during turn-off
        cur_req = "R8";
        req = 0; step(3);
        chk("R8", "turn-off wait", int'(state_o), 4);
        req = 1; step(3);
        chk("R8", "back to all on", int'(state_o), 3);
        chk("R8", "outputs kept", int'(en_o), 15);
        req = 0;
        wait_en(4'b0111, n);
        wait_en(4'b0011, n);
        req = 1;
        wait_en(4'b0111, n); chk("R8", "C back on after forward count", n, 3 + DC + 1);
        wait_en(4'b1111, n); chk("R8", "D back on", n, DD + 1);

        // R7 withdrawal mid turn-on
        cur_req = "R7";
        req = 0; wait_en(4'b0000, n);
        req = 1; wait_en(4'b0011, n);
        req = 0;
        wait_en(4'b0001, n); chk("R7", "highest off on third edge", n, 3);
        chk("R7", "turning-off code", int'(state_o), 5);
        wait_en(4'b0000, n); chk("R7", "A off after B count", n, DB + 1);
        req = 1; step(4);
        chk("R7", "start phase", int'(state_o), 1);
        req = 0; step(3);
        chk("R7", "abort start to idle", int'(state_o), 0);
        chk("R7", "nothing on", int'(en_o), 0);

        // R1 power-on reset hold
        cur_req = "R1";
        req = 1; wait_en(4'b1111, n);
        por = 1; step(1);
        chk("R1", "por clears enables", int'(en_o), 0);
        chk("R1", "por idle", int'(state_o), 0);
        chk("R1", "por fault", int'(fault_o), 1);
        step(5);
        chk("R1", "held during por", int'(en_o), 0);
        por = 0;
        wait_en(4'b1111, n);
        step(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule